// File: doc/BRIEF.md
# Cascaded Interrupt Vector Arbiter

This block sits between two eight-input interrupt controllers, with the second controller (the slave) hanging off input 2 of the first (the master), and a CPU that takes one interrupt request line and asks for a vector when it acknowledges. Each controller keeps its own request, mask and in-service state outside this block. Each one reports its highest eligible pin, whether it has already raised an interrupt, and its vector base. The arbiter decides when each controller raises. It forwards a slave request to the master as a one-cycle cascade pulse and holds the CPU request line. At acknowledge it forms the 8-bit vector and tells each controller which pin it has accepted.

An evaluation runs when the `eval` input pulses, which the owner does after any register write made while the controllers are ready. It also runs by itself in the cycle after a cascade pulse and in the cycle after an acceptance, so that the controllers have updated their flags before they are looked at again. Within one evaluation the slave is examined before the master.

Top module: `cascade_vec_arb`

## Requirements
- R1: After reset, `intr`, `vec_vld`, `cas_pulse`, `m_raise`, `m_acc` and `s_acc` are low and `vec` is zero.
- R2: An evaluation in which `s_raised` is low and `s_pin_vld` is high makes `cas_pulse` high for exactly the following cycle. If the slave is already raised or has no eligible pin, no pulse appears.
- R3: An evaluation in which `m_raised` is low and `m_pin_vld` is high makes `m_raise` high for the following cycle and sets `intr` in that same cycle. If the master is raised or has nothing eligible, neither happens.
- R4: Once set, `intr` stays high until an acknowledge and is low in the cycle after `ack`.
- R5: The cycle after `ack`, `vec_vld` is high for one cycle. `vec` then holds {`m_base[7:3]`, master pin}, where the master pin is `m_pin` when `m_pin_vld` is set and 7 (spurious) otherwise. `vec` keeps that value until the next acknowledge.
- R6: When the master pin chosen under R5 is 2, `vec` is {`s_base[7:3]`, slave pin} instead, where the slave pin is `s_pin`, or 7 when `s_pin_vld` is low.
- R7: In the cycle with `vec_vld`, if `vec[7:3]` equals `s_base[7:3]`, then `s_acc` is high with `s_acc_pin` = `vec[2:0]`, and `m_acc` is high with `m_acc_pin` = 2. Otherwise only `m_acc` is high, with `m_acc_pin` = `vec[2:0]`.
- R8: An evaluation runs without `eval` in the cycle after `cas_pulse` and in the cycle after `m_acc`. As a result, requests that are still pending are raised again with no further `eval` pulses, and a slave request reaches the CPU through master pin 2.
- R9: An `eval` pulse that arrives in an acknowledge cycle, or in a cycle where `m_acc` is high, does not raise anything by itself. The evaluation that follows the acceptance covers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval | input | 1 | Request an evaluation |
| ack | input | 1 | CPU interrupt acknowledge strobe |
| m_pin_vld | input | 1 | Master has an eligible pin |
| m_pin | input | 3 | Master highest eligible pin |
| m_raised | input | 1 | Master has already raised |
| m_base | input | 8 | Master vector base (low bits ignored) |
| s_pin_vld | input | 1 | Slave has an eligible pin |
| s_pin | input | 3 | Slave highest eligible pin |
| s_raised | input | 1 | Slave has already raised |
| s_base | input | 8 | Slave vector base (low bits ignored) |
| intr | output | 1 | Interrupt request to CPU |
| vec | output | 8 | Resolved vector |
| vec_vld | output | 1 | Vector valid strobe |
| cas_pulse | output | 1 | Slave raise and cascade pulse on master input 2 |
| m_raise | output | 1 | Master raise strobe |
| m_acc | output | 1 | Master accept strobe |
| m_acc_pin | output | 3 | Pin accepted by the master |
| s_acc | output | 1 | Slave accept strobe |
| s_acc_pin | output | 3 | Pin accepted by the slave |

## Verification
The assertions depend on the attached controllers reacting at the very next clock edge. A cascade pulse sets the slave's raised flag and master request 2, a raise strobe sets the master's raised flag, and an accept strobe clears the raised flag and the accepted request bit. Without that, the automatic re-evaluation would raise a second time. The bench drives the ports from stub controllers that follow exactly this rule. It issues `eval` only while nothing is being raised or accepted, and it always gives the two bases different upper five bits, so that each vector can be told apart by its base.

// File: rtl/cascade_vec_arb.sv
module cascade_vec_arb #(
  parameter int PIN_W   = 3,
  parameter int VEC_W   = 8,
  parameter int CAS_PIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic             ack,
  input  logic             m_pin_vld,
  input  logic [PIN_W-1:0] m_pin,
  input  logic             m_raised,
  input  logic [VEC_W-1:0] m_base,
  input  logic             s_pin_vld,
  input  logic [PIN_W-1:0] s_pin,
  input  logic             s_raised,
  input  logic [VEC_W-1:0] s_base,
  output logic             intr,
  output logic [VEC_W-1:0] vec,
  output logic             vec_vld,
  output logic             cas_pulse,
  output logic             m_raise,
  output logic             m_acc,
  output logic [PIN_W-1:0] m_acc_pin,
  output logic             s_acc,
  output logic [PIN_W-1:0] s_acc_pin
);
  localparam int BASE_W = VEC_W - PIN_W;
  localparam logic [PIN_W-1:0] SPUR = '1;
  localparam logic [PIN_W-1:0] CAS  = PIN_W'(CAS_PIN);

  logic auto_q;

  wire eval_go  = (eval | auto_q) & ~ack & ~m_acc;
  wire s_go     = eval_go & ~s_raised & s_pin_vld;
  wire m_go     = eval_go & ~m_raised & m_pin_vld;

  wire [PIN_W-1:0]  m_sel     = m_pin_vld ? m_pin : SPUR;
  wire [PIN_W-1:0]  s_sel     = s_pin_vld ? s_pin : SPUR;
  wire              via_slave = (m_sel == CAS);
  wire [VEC_W-1:0]  vec_d     = via_slave ? {s_base[VEC_W-1:PIN_W], s_sel}
                                          : {m_base[VEC_W-1:PIN_W], m_sel};
  wire [BASE_W-1:0] vec_hi    = vec_d[VEC_W-1:PIN_W];
  wire              to_slave  = (vec_hi == s_base[VEC_W-1:PIN_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intr      <= 1'b0;
      vec       <= '0;
      vec_vld   <= 1'b0;
      cas_pulse <= 1'b0;
      m_raise   <= 1'b0;
      m_acc     <= 1'b0;
      m_acc_pin <= '0;
      s_acc     <= 1'b0;
      s_acc_pin <= '0;
      auto_q    <= 1'b0;
    end else begin
      cas_pulse <= s_go;
      m_raise   <= m_go;
      auto_q    <= cas_pulse | m_acc;
      vec_vld   <= ack;
      m_acc     <= ack;
      s_acc     <= ack & to_slave;
      if (ack)       intr <= 1'b0;
      else if (m_go) intr <= 1'b1;
      if (ack) begin
        vec       <= vec_d;
        m_acc_pin <= to_slave ? CAS : vec_d[PIN_W-1:0];
        s_acc_pin <= vec_d[PIN_W-1:0];
      end
    end
  end
endmodule

module cascade_vec_arb_chk #(
  parameter int PIN_W = 3,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             intr,
  input logic             vec_vld,
  input logic             cas_pulse,
  input logic             m_raise,
  input logic             m_acc,
  input logic [PIN_W-1:0] m_acc_pin,
  input logic             s_acc
);
  a_r4_intr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !ack |=> intr);
  a_r4_intr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !intr);
  a_r3_intr_from_raise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> m_raise);
  a_r5_vld_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_vld && m_acc);
  a_r7_slave_implies_cas: assert property (@(posedge clk) disable iff (!rst_n)
    s_acc |-> m_acc && m_acc_pin == PIN_W'(2));
  a_r2_cas_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cas_pulse |=> !cas_pulse);
  a_r9_no_raise_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !m_raise && !cas_pulse);
endmodule

bind cascade_vec_arb cascade_vec_arb_chk #(.PIN_W(PIN_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .intr(intr), .vec_vld(vec_vld),
  .cas_pulse(cas_pulse), .m_raise(m_raise), .m_acc(m_acc),
  .m_acc_pin(m_acc_pin), .s_acc(s_acc)
);

// File: tb/cascade_vec_arb_tb.sv
`timescale 1ns/1ps
module cascade_vec_arb_tb;
  logic clk = 0, rst_n = 0, eval = 0, ack = 0;
  logic [7:0] m_base = 8'h20, s_base = 8'h70;
  logic intr, vec_vld, cas_pulse, m_raise, m_acc, s_acc;
  logic [7:0] vec;
  logic [2:0] m_acc_pin, s_acc_pin;
  logic [7:0] m_req, s_req, ld_m, ld_s;
  logic m_rsd, s_rsd, ld = 0, ld_mr = 0, ld_sr = 0;
  int total = 0, failed = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [3:0] hi_pin(input logic [7:0] r);
    for (int i = 0; i < 8; i++) if (r[i]) return {1'b1, 3'(i)};
    return 4'b0;
  endfunction

  wire [3:0] mh = hi_pin(m_req);
  wire [3:0] sh = hi_pin(s_req);

  cascade_vec_arb u_dut (
    .clk(clk), .rst_n(rst_n), .eval(eval), .ack(ack),
    .m_pin_vld(mh[3]), .m_pin(mh[2:0]), .m_raised(m_rsd), .m_base(m_base),
    .s_pin_vld(sh[3]), .s_pin(sh[2:0]), .s_raised(s_rsd), .s_base(s_base),
    .intr(intr), .vec(vec), .vec_vld(vec_vld), .cas_pulse(cas_pulse),
    .m_raise(m_raise), .m_acc(m_acc), .m_acc_pin(m_acc_pin),
    .s_acc(s_acc), .s_acc_pin(s_acc_pin)
  );

  always_ff @(posedge clk) begin
    if (ld) begin
      m_req <= ld_m; s_req <= ld_s; m_rsd <= ld_mr; s_rsd <= ld_sr;
    end else begin
      if (m_acc) begin m_rsd <= 1'b0; m_req[m_acc_pin] <= 1'b0; end
      if (s_acc) begin s_rsd <= 1'b0; s_req[s_acc_pin] <= 1'b0; end
      if (cas_pulse) begin s_rsd <= 1'b1; m_req[2] <= 1'b1; end
      if (m_raise) m_rsd <= 1'b1;
    end
  end

  function automatic logic [7:0] exp_vec(input logic [7:0] mr, sr, mb, sb);
    logic [3:0] a, b;
    logic [2:0] mp, sp;
    a = hi_pin(mr); b = hi_pin(sr);
    mp = a[3] ? a[2:0] : 3'd7;
    sp = b[3] ? b[2:0] : 3'd7;
    return (mp == 3'd2) ? {sb[7:3], sp} : {mb[7:3], mp};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] m, s, input logic mr, sr);
    ld_m = m; ld_s = s; ld_mr = mr; ld_sr = sr; ld = 1;
    step(1);
    ld = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic ack_check(input string tag);
    logic [7:0] e;
    e = exp_vec(m_req, s_req, m_base, s_base);
    ack = 1; step(1); ack = 0;
    chk({tag, " R5 vec_vld"}, vec_vld, 1);
    chk({tag, " R5/R6 vec"}, vec, e);
    chk({tag, " R4 intr low after ack"}, intr, 0);
    if (e[7:3] == s_base[7:3]) begin
      chk({tag, " R7 slave accept"}, {s_acc, s_acc_pin, m_acc, m_acc_pin}, {1'b1, e[2:0], 1'b1, 3'd2});
    end else begin
      chk({tag, " R7 master accept"}, {s_acc, m_acc, m_acc_pin}, {1'b0, 1'b1, e[2:0]});
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; failed++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    ld_m = 0; ld_s = 0; ld = 1;
    step(3);
    rst_n = 1; ld = 0;
    step(1);
    // R1 reset state
    chk("R1 reset outputs", {intr, vec_vld, cas_pulse, m_raise, m_acc, s_acc, vec}, 0);

    // R2 R3 R6 R7 R8: slave request routed through master pin 2
    load(8'h00, 8'h20, 0, 0);
    eval = 1; step(1); eval = 0;
    chk("R2 cascade pulse", cas_pulse, 1);
    chk("R3 no master raise yet", intr, 0);
    step(1);
    chk("R2 pulse one cycle", cas_pulse, 0);
    step(1);
    chk("R8 auto eval raises master", {m_raise, intr}, 2'b11);
    step(2);
    chk("R4 intr held", intr, 1);
    ack_check("slave path");
    step(3);
    chk("R8 nothing left", {intr, m_req, s_req}, 0);

    // R3 R4 R5 master only
    m_base = 8'h08;
    load(8'h10, 8'h00, 0, 0);
    eval = 1; step(1); eval = 0;
    chk("R3 master raise", {m_raise, intr, cas_pulse}, 3'b110);
    step(4);
    chk("R4 intr held long", intr, 1);
    ack_check("master only");
    chk("R5 vector value", vec, 8'h0C);
    step(2);
    chk("R5 vec holds", vec, 8'h0C);

    // R2 R3 raised flags suppress
    load(8'h02, 8'h08, 1, 1);
    eval = 1; step(1); eval = 0;
    chk("R2 R3 raised suppress", {cas_pulse, m_raise, intr}, 0);
    step(3);
    chk("R2 R3 still quiet", {cas_pulse, m_raise, intr}, 0);

    // R5 spurious master
    load(8'h00, 8'h00, 0, 0);
    ack_check("spurious master");
    chk("R5 spurious pin 7", vec, {m_base[7:3], 3'd7});

    // R6 spurious slave
    load(8'h04, 8'h00, 0, 0);
    ack_check("spurious slave");
    chk("R6 slave spurious 7", vec, {s_base[7:3], 3'd7});
    step(3);

    // R9 eval blocked during ack
    load(8'h28, 8'h00, 0, 0);
    eval = 1; ack = 1; step(1); eval = 0; ack = 0;
    chk("R9 no raise in ack cycle", {m_raise, intr}, 0);
    chk("R9 accept pin 3", {m_acc, m_acc_pin}, {1'b1, 3'd3});
    step(1);
    chk("R9 no raise in accept cycle", m_raise, 0);
    step(1);
    chk("R8 raise after accept", {m_raise, intr}, 2'b11);
    ack_check("after R9");
    step(3);

    // random scenarios
    for (int sc = 0; sc < 40; sc++) begin
      int n;
      logic [7:0] mr;
      m_base = 8'($urandom());
      do s_base = 8'($urandom()); while (s_base[7:3] == m_base[7:3]);
      mr = 8'($urandom()) & 8'hFB;
      load(mr, 8'($urandom()), 0, 0);
      eval = 1; step(1); eval = 0;
      n = 0;
      for (int k = 0; k < 40; k++) begin
        int w;
        w = 0;
        while (!intr && w < 8) begin step(1); w++; end
        if (!intr) break;
        ack_check("random");
        n++;
      end
      chk("R8 all requests delivered", {m_req, s_req}, 0);
    end

    done = 1;
    finish_run();
  end
endmodule